// File: doc/BRIEF.md
# DMA Read Chunk Splitter

This block turns one DMA read job into a stream of memory read requests. A job is a source address in host memory, a byte count and a destination address in local SRAM. Software-facing logic loads these three values with a load strobe and then starts the job. The block cuts the job into requests whose length depends on the configured maximum transfer size and on the alignment of the current address, keeps the number of unanswered requests under a configurable limit, and writes every returned response into the local SRAM port at an address that advances by the returned length.

Responses come back in request order, one beat per request, each tagged with its length. When every byte has been requested and every response has come back, the block emits a one-cycle completion pulse and, if the interrupt target captured at start selects the host, a one-cycle interrupt pulse. A start that arrives while a job is still running is dropped and latches a sticky error flag.

Top module: `dma_rd_splitter`

## Requirements
- R1: After reset `busy`, `req_valid`, `done`, `irq`, `err_start` are 0 and `bytes_left` is 0.
- R2: `cfg_xfer_size` selects the largest request: 0 = 64 bytes, 1 = 128 bytes, 2 and 3 = 256 bytes. Unless R3 applies, a request is cut at the next address that is a multiple of that size, so it never crosses such a boundary.
- R3: With `cfg_split_en` = 1 and size 128, a request starting at an address that is not a multiple of 128 is cut at the next multiple of 64; from a 128-aligned address a full 128-byte request is allowed.
- R4: The byte count may be any value; the final request carries only the remaining bytes. A job of zero bytes issues no request and still completes.
- R5: At most L requests are outstanding, where L is `cfg_max_pend` clamped to 12 when above 12 and taken as 1 when 0.
- R6: `job_start` begins a job only if source, destination and count were loaded (`job_load`) since the previous job began; otherwise it is ignored and the block stays idle.
- R7: `job_start` while `busy` is ignored (the running job and `bytes_left` are unchanged) and sets `err_start`, which stays 1 until reset.
- R8: `bytes_left` equals the job count at start and drops by `req_len` on every accepted request (`req_valid` and `req_ready`).
- R9: Each response drives `sram_we` in the same cycle; `sram_addr` starts at the loaded destination and advances by `rsp_len` after each response.
- R10: `done` pulses for one cycle on the second clock edge after the last response (one edge after the job ends if no request was issued), and `busy` is 0 in that cycle.
- R11: `irq` pulses together with `done` only if `cfg_irq_host` was 1 when the job started.
- R12: While `req_valid` is 1 and `req_ready` is 0, the request address and length hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_max_pend | input | 4 | Outstanding request limit (clamped) |
| cfg_xfer_size | input | 2 | Maximum request size code |
| cfg_split_en | input | 1 | 64-byte cut for unaligned 128-byte mode |
| cfg_irq_host | input | 1 | Completion interrupt goes to host |
| job_src | input | AW | Host source address |
| job_dst | input | SW | SRAM destination address |
| job_len | input | LW | Job byte count |
| job_load | input | 1 | Load source, destination and count |
| job_start | input | 1 | Start the loaded job |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | AW | Read request address |
| req_len | output | 9 | Read request length in bytes |
| rsp_valid | input | 1 | Read response valid |
| rsp_len | input | 9 | Response length in bytes |
| rsp_data | input | DW | Response payload |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | SW | SRAM write address |
| sram_len | output | 9 | SRAM write length |
| sram_data | output | DW | SRAM write data |
| busy | output | 1 | Job running or responses outstanding |
| done | output | 1 | Job completion pulse |
| irq | output | 1 | Host interrupt pulse |
| bytes_left | output | LW | Bytes not yet requested |
| err_start | output | 1 | Sticky start-while-busy error |

## Verification
On every cycle the assertions hold the outstanding count under the cap, keep requests stable under back-pressure, forbid a request longer than the remaining count or one crossing a 64-byte line in split mode, tie `bytes_left` to accepted lengths, and keep `done`, `irq` and the error flag consistent. The exact request sequence for each size and alignment, the clamped limit value, the SRAM address walk, the ignored starts and the interrupt selection can only be shown by the directed scenarios, which compare every request and response against lengths worked out by hand.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
   typedef enum logic [1:0] {
      SZ_64  = 2'd0,
      SZ_128 = 2'd1,
      SZ_256 = 2'd2,
      SZ_MAX = 2'd3
   } xfer_size_e;

   localparam int unsigned CHUNK_W = 9;

   function automatic logic [CHUNK_W-1:0] size_bytes(input xfer_size_e sz);
      case (sz)
         SZ_64:   return 9'd64;
         SZ_128:  return 9'd128;
         default: return 9'd256;
      endcase
   endfunction
endpackage

// File: rtl/dma_split_cfg.sv
module dma_split_cfg #(
   parameter int unsigned CFG_W = 4,
   parameter int unsigned CAP   = 12,
   parameter int unsigned CW    = 4
) (
   input  logic [CFG_W-1:0] raw_limit,
   output logic [CW-1:0]    eff_limit
);
   initial begin
      assert (CAP >= 1 && CAP < (1 << CFG_W) && CAP < (1 << CW))
         else $error("dma_split_cfg: CAP out of range");
   end

   always_comb begin
      if (raw_limit == '0)
         eff_limit = CW'(1);
      else if (32'(raw_limit) > CAP)
         eff_limit = CW'(CAP);
      else
         eff_limit = CW'(raw_limit);
   end
endmodule

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc
   import dma_split_pkg::*;
#(
   parameter int unsigned LW            = 20,
   parameter bit          SPLIT_SUPPORT = 1'b1
) (
   input  logic [7:0]         addr_lo,
   input  logic [LW-1:0]      remain,
   input  xfer_size_e         size,
   input  logic               split_en,
   output logic [CHUNK_W-1:0] chunk_len
);
   initial begin
      assert (LW >= CHUNK_W) else $error("dma_chunk_calc: LW too small");
   end

   logic [CHUNK_W-1:0] lim;
   logic [CHUNK_W-1:0] off;
   logic [CHUNK_W-1:0] room_full;
   logic [CHUNK_W-1:0] room;

   always_comb begin
      lim       = size_bytes(size);
      off       = {1'b0, addr_lo} & (lim - 9'd1);
      room_full = lim - off;
   end

   generate
      if (SPLIT_SUPPORT) begin : g_split
         logic cut64;
         always_comb begin
            cut64 = split_en && (size == SZ_128) && (addr_lo[6:0] != 7'd0);
            room  = cut64 ? (9'd64 - {3'b000, addr_lo[5:0]}) : room_full;
         end
      end else begin : g_nosplit
         logic unused_split;
         always_comb begin
            unused_split = split_en;
            room         = room_full;
         end
      end
   endgenerate

   always_comb begin
      if (remain < LW'(room))
         chunk_len = remain[CHUNK_W-1:0];
      else
         chunk_len = room;
   end
endmodule

// File: rtl/dma_pend_track.sv
module dma_pend_track #(
   parameter int unsigned CAP = 12,
   parameter int unsigned CW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] count,
   output logic          full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (inc && !dec)
         count <= count + CW'(1);
      else if (dec && !inc)
         count <= count - CW'(1);
   end

   assign full = (count >= limit);

   p_pend_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(count) <= CAP);

   p_no_issue_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && full) |-> dec);
endmodule

// File: rtl/dma_rd_splitter.sv
module dma_rd_splitter
   import dma_split_pkg::*;
#(
   parameter int unsigned AW            = 40,
   parameter int unsigned SW            = 16,
   parameter int unsigned LW            = 20,
   parameter int unsigned DW            = 64,
   parameter int unsigned CFG_W         = 4,
   parameter int unsigned PEND_CAP      = 12,
   parameter bit          SPLIT_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_max_pend,
   input  logic [1:0]       cfg_xfer_size,
   input  logic             cfg_split_en,
   input  logic             cfg_irq_host,
   input  logic [AW-1:0]    job_src,
   input  logic [SW-1:0]    job_dst,
   input  logic [LW-1:0]    job_len,
   input  logic             job_load,
   input  logic             job_start,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [AW-1:0]    req_addr,
   output logic [8:0]       req_len,
   input  logic             rsp_valid,
   input  logic [8:0]       rsp_len,
   input  logic [DW-1:0]    rsp_data,
   output logic             sram_we,
   output logic [SW-1:0]    sram_addr,
   output logic [8:0]       sram_len,
   output logic [DW-1:0]    sram_data,
   output logic             busy,
   output logic             done,
   output logic             irq,
   output logic [LW-1:0]    bytes_left,
   output logic             err_start
);
   localparam int unsigned CW = $clog2(PEND_CAP + 1);

   initial begin
      assert (AW >= 8 && SW >= 1 && DW >= 1)
         else $error("dma_rd_splitter: bad width parameter");
   end

   logic [AW-1:0]      src_q;
   logic [SW-1:0]      dst_q;
   logic [LW-1:0]      len_q;
   logic               loaded;
   logic               active;
   logic [AW-1:0]      cur_addr;
   logic [LW-1:0]      remain;
   logic [SW-1:0]      wr_ptr;
   logic               irq_sel;
   logic               done_q;
   logic               irq_q;
   logic               err_q;
   logic [CW-1:0]      eff_limit;
   logic [CW-1:0]      pend_cnt;
   logic               pend_full;
   logic [CHUNK_W-1:0] chunk_len;
   logic               fire;
   logic               accept;
   logic               finish;

   dma_split_cfg #(.CFG_W(CFG_W), .CAP(PEND_CAP), .CW(CW)) i_cfg (
      .raw_limit (cfg_max_pend),
      .eff_limit (eff_limit)
   );

   dma_chunk_calc #(.LW(LW), .SPLIT_SUPPORT(SPLIT_SUPPORT)) i_calc (
      .addr_lo   (cur_addr[7:0]),
      .remain    (remain),
      .size      (xfer_size_e'(cfg_xfer_size)),
      .split_en  (cfg_split_en),
      .chunk_len (chunk_len)
   );

   dma_pend_track #(.CAP(PEND_CAP), .CW(CW)) i_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fire),
      .dec   (rsp_valid),
      .limit (eff_limit),
      .count (pend_cnt),
      .full  (pend_full)
   );

   assign busy      = active || (pend_cnt != '0);
   assign req_valid = active && (remain != '0) && !pend_full;
   assign req_addr  = cur_addr;
   assign req_len   = chunk_len;
   assign fire      = req_valid && req_ready;
   assign accept    = job_start && !busy && loaded;
   assign finish    = active && (remain == '0) && (pend_cnt == '0);

   assign sram_we   = rsp_valid;
   assign sram_addr = wr_ptr;
   assign sram_len  = rsp_len;
   assign sram_data = rsp_data;

   assign done       = done_q;
   assign irq        = irq_q;
   assign bytes_left = remain;
   assign err_start  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         len_q  <= '0;
         loaded <= 1'b0;
      end else if (job_load) begin
         src_q  <= job_src;
         dst_q  <= job_dst;
         len_q  <= job_len;
         loaded <= 1'b1;
      end else if (accept) begin
         loaded <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
         irq_sel  <= 1'b0;
      end else if (accept) begin
         active   <= 1'b1;
         cur_addr <= src_q;
         remain   <= len_q;
         irq_sel  <= cfg_irq_host;
      end else begin
         if (fire) begin
            cur_addr <= cur_addr + AW'(chunk_len);
            remain   <= remain - LW'(chunk_len);
         end
         if (finish)
            active <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_ptr <= '0;
      else if (accept)
         wr_ptr <= dst_q;
      else if (rsp_valid)
         wr_ptr <= wr_ptr + SW'(rsp_len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= finish;
         irq_q  <= finish && irq_sel;
         if (job_start && busy)
            err_q <= 1'b1;
      end
   end

   p_len_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != 9'd0) && (LW'(req_len) <= bytes_left));

   p_size_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len <= 9'd256));

   generate
      if (SPLIT_SUPPORT) begin : g_split_chk
         p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cfg_split_en && cfg_xfer_size == 2'd1 && req_addr[6:0] != 7'd0)
            |-> ((10'(req_addr[5:0]) + 10'(req_len)) <= 10'd64));
      end
   endgenerate

   p_bytes_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (bytes_left == $past(bytes_left) - LW'($past(req_len))));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_start |=> err_start);

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_irq_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);

   p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));
endmodule

// File: tb/test_dma_rd_splitter.sv
module test_dma_rd_splitter;
   localparam int CLK_P = 10;
   localparam int AW = 40;
   localparam int SW = 16;
   localparam int LW = 20;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    cfg_max_pend = 4'd4;
   logic [1:0]    cfg_xfer_size = 2'd0;
   logic          cfg_split_en = 1'b0;
   logic          cfg_irq_host = 1'b0;
   logic [AW-1:0] job_src = '0;
   logic [SW-1:0] job_dst = '0;
   logic [LW-1:0] job_len = '0;
   logic          job_load = 1'b0;
   logic          job_start = 1'b0;
   logic          req_valid;
   logic          req_ready = 1'b1;
   logic [AW-1:0] req_addr;
   logic [8:0]    req_len;
   logic          rsp_valid = 1'b0;
   logic [8:0]    rsp_len = '0;
   logic [DW-1:0] rsp_data = '0;
   logic          sram_we;
   logic [SW-1:0] sram_addr;
   logic [8:0]    sram_len;
   logic [DW-1:0] sram_data;
   logic          busy;
   logic          done;
   logic          irq;
   logic [LW-1:0] bytes_left;
   logic          err_start;

   int checks = 0;
   int errors = 0;
   int exp_len [20];
   int rq [20];

   always #(CLK_P/2) clk = ~clk;

   dma_rd_splitter i_dma_rd_splitter (
      .clk(clk), .rst_n(rst_n),
      .cfg_max_pend(cfg_max_pend), .cfg_xfer_size(cfg_xfer_size),
      .cfg_split_en(cfg_split_en), .cfg_irq_host(cfg_irq_host),
      .job_src(job_src), .job_dst(job_dst), .job_len(job_len),
      .job_load(job_load), .job_start(job_start),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
      .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
      .sram_we(sram_we), .sram_addr(sram_addr), .sram_len(sram_len), .sram_data(sram_data),
      .busy(busy), .done(done), .irq(irq), .bytes_left(bytes_left), .err_start(err_start)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_job(input longint src, input int dst, input int len,
                          input int size, input bit split, input bit irqh,
                          input int lim_cfg, input int hold, input int exp_pend,
                          input bit stall, input bit poke, input int exp_n);
      longint cum = 0;
      int     rcum = 0;
      int     k = 0;
      int     head = 0;
      int     frozen = 0;
      bit     seen = 1'b0;
      @(negedge clk);
      cfg_xfer_size = 2'(size);
      cfg_split_en  = split;
      cfg_irq_host  = irqh;
      cfg_max_pend  = 4'(lim_cfg);
      job_src = AW'(src); job_dst = SW'(dst); job_len = LW'(len);
      job_load = 1'b1;
      @(negedge clk);
      job_load = 1'b0;
      job_start = 1'b1;
      for (int it = 0; it < 3000; it++) begin
         @(negedge clk);
         if (it == 0) job_start = 1'b0;
         if (done) begin seen = 1'b1; break; end
         if (poke && it == hold - 4) begin
            frozen = int'(bytes_left);
            job_start = 1'b1;
         end
         if (poke && it == hold - 3) begin
            job_start = 1'b0;
            check("R7 err_start after start while busy", err_start, 1);
            check("R7 bytes_left unchanged", bytes_left, frozen);
            check("R7 job still busy", busy, 1);
         end
         if (exp_pend > 0 && it == hold)
            check("R5 outstanding requests at limit", k, exp_pend);
         if (it >= hold && head < k) begin
            rsp_valid = 1'b1;
            rsp_len   = 9'(rq[head]);
            rsp_data  = DW'(head);
            check("R9 sram_addr before response", sram_addr, SW'(dst + rcum));
            #1;
            check("R9 sram_we follows response", sram_we, 1);
            rcum += rq[head];
            head++;
         end else begin
            rsp_valid = 1'b0;
         end
         req_ready = stall ? 1'(it % 2) : 1'b1;
         if (req_valid && req_ready) begin
            if (k < exp_n) begin
               check("R2/R3/R12 request address", req_addr, AW'(src + cum));
               check("R2/R3/R4 request length", req_len, exp_len[k]);
               check("R8 bytes_left before request", bytes_left, LW'(len - cum));
               rq[k] = int'(req_len);
            end else begin
               check("R4 no extra request", k, exp_n - 1);
            end
            cum += req_len;
            k++;
         end
      end
      rsp_valid = 1'b0;
      req_ready = 1'b1;
      check("R10 job completed", seen, 1);
      check("R4 request count", k, exp_n);
      check("R8 bytes_left at end", bytes_left, 0);
      check("R10 busy low at done", busy, 0);
      check("R11 irq follows target", irq, irqh);
      @(negedge clk);
      check("R10 done is one cycle", done, 0);
      check("R11 irq is one cycle", irq, 0);
   endtask

   task automatic t_reset;
      check("R1 busy", busy, 0);
      check("R1 req_valid", req_valid, 0);
      check("R1 done", done, 0);
      check("R1 irq", irq, 0);
      check("R1 err_start", err_start, 0);
      check("R1 bytes_left", bytes_left, 0);
   endtask

   task automatic t_start_unloaded;
      @(negedge clk);
      job_start = 1'b1;
      @(negedge clk);
      job_start = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R6 unloaded start stays idle", busy, 0);
         check("R6 unloaded start no request", req_valid, 0);
         check("R6 unloaded start no done", done, 0);
      end
      check("R6 unloaded start is no error", err_start, 0);
   endtask

   task automatic t_size64;
      exp_len[0] = 48; exp_len[1] = 64; exp_len[2] = 64; exp_len[3] = 24;
      run_job(64'h1010, 16'h100, 200, 0, 1'b0, 1'b1, 4, 0, 0, 1'b0, 1'b0, 4);
   endtask

   task automatic t_size128_plain;
      exp_len[0] = 96; exp_len[1] = 128; exp_len[2] = 76;
      run_job(64'h20, 16'h400, 300, 1, 1'b0, 1'b0, 4, 0, 0, 1'b0, 1'b0, 3);
   endtask

   task automatic t_size128_split;
      exp_len[0] = 32; exp_len[1] = 64; exp_len[2] = 128; exp_len[3] = 76;
      run_job(64'h20, 16'h800, 300, 1, 1'b1, 1'b1, 4, 0, 0, 1'b1, 1'b0, 4);
   endtask

   task automatic t_size256;
      exp_len[0] = 256; exp_len[1] = 256; exp_len[2] = 1;
      run_job(64'h0, 16'h10, 513, 2, 1'b0, 1'b1, 3, 0, 0, 1'b0, 1'b0, 3);
      exp_len[0] = 128; exp_len[1] = 172;
      run_job(64'h80, 16'h20, 300, 3, 1'b1, 1'b0, 3, 0, 0, 1'b0, 1'b0, 2);
   endtask

   task automatic t_limit_clamp;
      for (int i = 0; i < 15; i++) exp_len[i] = 64;
      exp_len[15] = 40;
      run_job(64'h0, 16'h0, 1000, 0, 1'b0, 1'b1, 15, 30, 12, 1'b0, 1'b0, 16);
   endtask

   task automatic t_limit_zero_and_busy_start;
      exp_len[0] = 64; exp_len[1] = 64; exp_len[2] = 64; exp_len[3] = 8;
      check("R7 no error before", err_start, 0);
      run_job(64'h3000, 16'h40, 200, 0, 1'b0, 1'b0, 0, 10, 1, 1'b0, 1'b1, 4);
      check("R7 error stays set", err_start, 1);
   endtask

   task automatic t_limit_two;
      exp_len[0] = 64; exp_len[1] = 64; exp_len[2] = 64;
      run_job(64'h40, 16'h0, 192, 0, 1'b0, 1'b0, 2, 8, 2, 1'b0, 1'b0, 3);
   endtask

   task automatic t_zero_len;
      run_job(64'h55, 16'h33, 0, 0, 1'b0, 1'b1, 4, 0, 0, 1'b0, 1'b0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_start_unloaded();
      t_size64();
      t_size128_plain();
      t_size128_split();
      t_size256();
      t_limit_clamp();
      t_limit_two();
      t_zero_len();
      t_limit_zero_and_busy_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule